// File: doc/BRIEF.md
# Serial Packet-Buffer Access Controller

This block is the serial slave front end of a radio-style packet buffer. The host drives a mode-0 serial bus with chip-select, clock and data. The controller splits the incoming stream into bytes and decodes an address byte. It then runs one of three operations: a command strobe, a 16-bit register access handed to the chip's register bank, or a burst into one of two 128-byte byte queues. The transmit queue is filled by the host and drained by the radio. The receive queue is filled by the radio, and the host can also write it, and the host reads it.

One chip-select low period may hold any number of strobes and register accesses in a row. A queue burst is different. Once it has begun, every later byte counts as queue data until chip-select rises. The controller returns a status byte during every address byte. It also returns the status byte during every data byte of a transmit-queue write. Two strobe codes empty the queues. All serial pins are taken to be synchronous to `clk`, and the serial clock half-period must be at least two `clk` cycles.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: An address byte carries the read flag in bit 6 (1 = read) and the address in bits 5:0. While it is shifted in, the slave shifts out the status byte. Status bit 0 is high when the receive queue holds data, bit 1 is the transmit underflow flag, bit 2 the transmit overflow flag, bit 3 the receive overflow flag, and bits 7:4 are zero.
- R2: Addresses 0x00 to 0x0F are strobes, whatever the read flag. A strobe gives a one-cycle `strobe_pulse` with `strobe_code` equal to address bits 3:0. A strobe takes no data byte, so the next byte is decoded as an address.
- R3: Strobe 0x08 empties the transmit queue and clears the transmit underflow and overflow flags. Strobe 0x09 empties the receive queue and clears the receive overflow flag.
- R4: Every other address except 0x3E and 0x3F is a register access with exactly two data bytes, high byte first. A write pulses `reg_wr` for one cycle with the 16-bit value after the second byte. A read returns `reg_rdata` high byte then low byte. The next byte after either is an address.
- R5: Address 0x3E with the read flag clear starts a transmit-queue write burst. Each data byte is appended, even one whose value looks like a strobe. The status byte is echoed during each data byte, and the burst lasts until chip-select rises.
- R6: A read of address 0x3E returns 0x00 for every data byte and leaves the transmit queue unchanged.
- R7: A read of address 0x3F returns receive-queue bytes in arrival order. When the queue is empty it returns 0x00 and removes nothing.
- R8: A write of address 0x3F appends each data byte to the receive queue.
- R9: A write to a full queue is dropped and sets that queue's overflow flag. The flag stays set until that queue's flush strobe.
- R10: A radio pop from an empty transmit queue sets the transmit underflow flag. The flag stays set until strobe 0x08.
- R11: When chip-select rises in the middle of a byte, the partial byte is discarded and the decoder returns to expecting an address byte.
- R12: Serial timing is mode 0, most significant bit first. The first output bit is valid before the first rising clock edge. Output bits change only after falling edges.
- R13: Each queue holds 128 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip-select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low while deselected |
| strobe_pulse | output | 1 | One-cycle pulse for each decoded strobe |
| strobe_code | output | 4 | Code of the last strobe |
| reg_addr | output | 6 | Address of the current register access |
| reg_wr | output | 1 | One-cycle register write pulse |
| reg_wdata | output | 16 | Register write value |
| reg_rdata | input | 16 | Register read value for `reg_addr` |
| tx_pop | input | 1 | Radio removes the head of the transmit queue |
| tx_data | output | 8 | Head byte of the transmit queue |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_push | input | 1 | Radio appends `rx_data` to the receive queue |
| rx_data | input | 8 | Byte from the radio |
| rx_full | output | 1 | Receive queue is full |

## Verification
A decoder left in the wrong state shows up on the next address byte. Either the expected strobe pulse is missing, or a strobe-valued byte lands in the transmit queue, visible when the radio drains it. A bad queue pointer shows up as a wrong or missing byte on the next drain or serial read. A sticky flag that is lost or set falsely appears in the status byte shifted out during the very next address byte. A bit-counter slip misaligns every following byte of the session, so the first returned byte after the fault is already wrong.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int          HDR_ADDR_W   = 6;
    localparam logic [5:0]  ADDR_TXQ     = 6'h3E;
    localparam logic [5:0]  ADDR_RXQ     = 6'h3F;
    localparam logic [5:0]  STROBE_END   = 6'h10;
    localparam logic [3:0]  STB_FLUSH_TX = 4'h8;
    localparam logic [3:0]  STB_FLUSH_RX = 4'h9;

    typedef enum logic [2:0] {
        DEC_ADDR,
        DEC_REG_HI,
        DEC_REG_LO,
        DEC_TXQ,
        DEC_RXQ
    } dec_state_e;

    typedef struct packed {
        logic [3:0] zero;
        logic       rx_ovf;
        logic       tx_ovf;
        logic       tx_udf;
        logic       rx_avail;
    } status_t;

    typedef struct packed {
        logic                  rd;
        logic [HDR_ADDR_W-1:0] addr;
    } hdr_t;

    function automatic hdr_t split_hdr(input logic [7:0] b);
        hdr_t h;
        h.rd   = b[6];
        h.addr = b[5:0];
        return h;
    endfunction

    function automatic logic is_strobe(input logic [HDR_ADDR_W-1:0] a);
        return a < STROBE_END;
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn,
    input  logic              sclk,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] next_byte,
    output logic              miso,
    output logic              load_pulse,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_q, csn_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] in_sr, out_sr;
    logic              rise, fall, cs_start;

    assign rise       = !csn && sclk && !sclk_q;
    assign fall       = !csn && !sclk && sclk_q;
    assign cs_start   = !csn && csn_q;
    assign load_pulse = cs_start || (fall && bit_cnt == '0);
    assign miso       = !csn && out_sr[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            csn_q     <= 1'b1;
            bit_cnt   <= '0;
            in_sr     <= '0;
            out_sr    <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else begin
            sclk_q    <= sclk;
            csn_q     <= csn;
            byte_done <= 1'b0;
            if (csn) begin
                bit_cnt <= '0;
            end else if (rise) begin
                in_sr   <= {in_sr[BYTE_W-2:0], mosi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_done <= 1'b1;
                    byte_val  <= {in_sr[BYTE_W-2:0], mosi};
                end
            end
            if (load_pulse)
                out_sr <= next_byte;
            else if (fall)
                out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
        end
    end

    // R11: a deselect always leaves the bit counter at the byte boundary
    assert_cnt_cleared_R11: assert property (@(posedge clk) disable iff (rst)
        csn |=> bit_cnt == '0);

    // R12: the output shifter holds still while the serial clock is high
    assert_out_stable_high_R12: assert property (@(posedge clk) disable iff (rst)
        (!csn && !csn_q && sclk && sclk_q) |=> $stable(out_sr));

endmodule

// File: rtl/byte_queue.sv
module byte_queue #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr, rd_ptr, count;
    logic             do_push, do_pop;

    assign count   = wr_ptr - rd_ptr;
    assign empty   = count == '0;
    assign full    = count == (AW+1)'(DEPTH);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
    end

    // R9: a push into a full queue changes nothing
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(count));

    // R7: a pop from an empty queue changes nothing
    assert_no_underrun_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> $stable(count));

    // R3: flush leaves the queue empty
    assert_flush_empties_R3: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
    import spi_fifo_pkg::*;
#(
    parameter int TXQ_DEPTH = 128,
    parameter int RXQ_DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_csn,
    input  logic        spi_sclk,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        strobe_pulse,
    output logic [3:0]  strobe_code,
    output logic [5:0]  reg_addr,
    output logic        reg_wr,
    output logic [15:0] reg_wdata,
    input  logic [15:0] reg_rdata,
    input  logic        tx_pop,
    output logic [7:0]  tx_data,
    output logic        tx_empty,
    input  logic        rx_push,
    input  logic [7:0]  rx_data,
    output logic        rx_full
);
    dec_state_e dec_q;
    logic       hdr_rd_q, rd_armed_q;
    logic [7:0] hi_q;
    logic       tx_udf_q, tx_ovf_q, rx_ovf_q;

    logic       load_pulse, byte_done;
    logic [7:0] byte_val, next_byte;
    hdr_t       hdr;
    status_t    status;

    logic       tx_push, tx_full;
    logic       rx_spi_push, rx_q_push, rx_pop, rx_empty;
    logic [7:0] rx_q_wdata, rx_head;
    logic       strobe_hit, flush_tx, flush_rx;

    spi_byte_shifter #(.BYTE_W(8)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .csn        (spi_csn),
        .sclk       (spi_sclk),
        .mosi       (spi_mosi),
        .next_byte  (next_byte),
        .miso       (spi_miso),
        .load_pulse (load_pulse),
        .byte_done  (byte_done),
        .byte_val   (byte_val)
    );

    assign hdr         = split_hdr(byte_val);
    assign strobe_hit  = byte_done && !spi_csn && dec_q == DEC_ADDR && is_strobe(hdr.addr);
    assign flush_tx    = strobe_hit && byte_val[3:0] == STB_FLUSH_TX;
    assign flush_rx    = strobe_hit && byte_val[3:0] == STB_FLUSH_RX;
    assign tx_push     = byte_done && !spi_csn && dec_q == DEC_TXQ && !hdr_rd_q;
    assign rx_spi_push = byte_done && !spi_csn && dec_q == DEC_RXQ && !hdr_rd_q;
    assign rx_pop      = byte_done && !spi_csn && dec_q == DEC_RXQ && hdr_rd_q && rd_armed_q;

    // the radio has priority on the receive write port
    assign rx_q_push  = rx_push || rx_spi_push;
    assign rx_q_wdata = rx_push ? rx_data : byte_val;

    byte_queue #(.DEPTH(TXQ_DEPTH), .WIDTH(8)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_tx),
        .push  (tx_push),
        .wdata (byte_val),
        .pop   (tx_pop),
        .rdata (tx_data),
        .empty (tx_empty),
        .full  (tx_full)
    );

    byte_queue #(.DEPTH(RXQ_DEPTH), .WIDTH(8)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_rx),
        .push  (rx_q_push),
        .wdata (rx_q_wdata),
        .pop   (rx_pop),
        .rdata (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    always_comb begin
        status          = '0;
        status.rx_avail = !rx_empty;
        status.tx_udf   = tx_udf_q;
        status.tx_ovf   = tx_ovf_q;
        status.rx_ovf   = rx_ovf_q;
    end

    always_comb begin
        unique case (dec_q)
            DEC_ADDR:   next_byte = status;
            DEC_TXQ:    next_byte = hdr_rd_q ? 8'h00 : status;
            DEC_RXQ:    next_byte = (hdr_rd_q && !rx_empty) ? rx_head : 8'h00;
            DEC_REG_HI: next_byte = hdr_rd_q ? reg_rdata[15:8] : 8'h00;
            DEC_REG_LO: next_byte = hdr_rd_q ? reg_rdata[7:0] : 8'h00;
            default:    next_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q        <= DEC_ADDR;
            hdr_rd_q     <= 1'b0;
            rd_armed_q   <= 1'b0;
            hi_q         <= '0;
            reg_addr     <= '0;
            reg_wr       <= 1'b0;
            reg_wdata    <= '0;
            strobe_pulse <= 1'b0;
            strobe_code  <= '0;
            tx_udf_q     <= 1'b0;
            tx_ovf_q     <= 1'b0;
            rx_ovf_q     <= 1'b0;
        end else begin
            strobe_pulse <= strobe_hit;
            reg_wr       <= 1'b0;
            if (strobe_hit) strobe_code <= byte_val[3:0];

            if (flush_tx) begin
                tx_udf_q <= 1'b0;
                tx_ovf_q <= 1'b0;
            end else begin
                if (tx_pop && tx_empty) tx_udf_q <= 1'b1;
                if (tx_push && tx_full) tx_ovf_q <= 1'b1;
            end
            if (flush_rx)
                rx_ovf_q <= 1'b0;
            else if ((rx_push && rx_full) || (rx_spi_push && (rx_full || rx_push)))
                rx_ovf_q <= 1'b1;

            if (spi_csn)
                rd_armed_q <= 1'b0;
            else if (load_pulse)
                rd_armed_q <= dec_q == DEC_RXQ && hdr_rd_q && !rx_empty;

            if (spi_csn) begin
                dec_q <= DEC_ADDR;
            end else if (byte_done) begin
                unique case (dec_q)
                    DEC_ADDR: begin
                        hdr_rd_q <= hdr.rd;
                        if (is_strobe(hdr.addr)) begin
                            dec_q <= DEC_ADDR;
                        end else if (hdr.addr == ADDR_TXQ) begin
                            dec_q <= DEC_TXQ;
                        end else if (hdr.addr == ADDR_RXQ) begin
                            dec_q <= DEC_RXQ;
                        end else begin
                            dec_q    <= DEC_REG_HI;
                            reg_addr <= hdr.addr;
                        end
                    end
                    DEC_REG_HI: begin
                        hi_q  <= byte_val;
                        dec_q <= DEC_REG_LO;
                    end
                    DEC_REG_LO: begin
                        if (!hdr_rd_q) begin
                            reg_wr    <= 1'b1;
                            reg_wdata <= {hi_q, byte_val};
                        end
                        dec_q <= DEC_ADDR;
                    end
                    default: dec_q <= dec_q;
                endcase
            end
        end
    end

    // R11: deselect returns the decoder to address decoding
    assert_csn_resets_decoder_R11: assert property (@(posedge clk) disable iff (rst)
        spi_csn |=> dec_q == DEC_ADDR);

    // R2: a strobe leaves the decoder waiting for an address
    assert_strobe_keeps_addr_R2: assert property (@(posedge clk) disable iff (rst)
        strobe_pulse |-> dec_q == DEC_ADDR);

    // R4: a register write completes the access
    assert_regwr_ends_access_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (dec_q == DEC_ADDR && $past(dec_q) == DEC_REG_LO));

    // R10: the underflow flag holds until a transmit flush
    assert_udf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_udf_q && !flush_tx) |=> tx_udf_q);

    // R6: a transmit read burst never appends to the queue
    assert_txq_readonly_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_q == DEC_TXQ && hdr_rd_q && tx_empty && !tx_pop) |=> tx_empty);

endmodule

// File: tb/tb_spi_fifo_ctrl.sv
module tb_spi_fifo_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic        spi_miso;
    logic        strobe_pulse;
    logic [3:0]  strobe_code;
    logic [5:0]  reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_empty;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_full;

    int total = 0;
    int fails = 0;
    int stb_count = 0;
    logic [3:0] stb_last = 4'h0;
    logic [15:0] regs [64];
    bit done = 0;

    always #5 clk = ~clk;

    spi_fifo_ctrl dut (
        .clk(clk), .rst(rst),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .strobe_pulse(strobe_pulse), .strobe_code(strobe_code),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full)
    );

    assign reg_rdata = regs[reg_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) regs[i] <= 16'h0;
            stb_count <= 0;
        end else begin
            if (reg_wr) regs[reg_addr] <= reg_wdata;
            if (strobe_pulse) begin
                stb_count <= stb_count + 1;
                stb_last  <= strobe_code;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        spi_csn = 1'b0;
        wait_clk(4);
    endtask

    task automatic cs_high();
        wait_clk(4);
        spi_csn = 1'b1;
        wait_clk(4);
    endtask

    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = mo[i];
            wait_clk(4);
            mi[i] = spi_miso;
            spi_sclk = 1'b1;
            wait_clk(4);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic partial(input logic [7:0] mo, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = mo[i];
            wait_clk(4);
            spi_sclk = 1'b1;
            wait_clk(4);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic read_status(output logic [7:0] st);
        cs_low();
        xfer(8'h0F, st);
        cs_high();
    endtask

    task automatic strobe(input logic [7:0] code);
        logic [7:0] d;
        cs_low();
        xfer(code, d);
        cs_high();
    endtask

    task automatic radio_push(input logic [7:0] b);
        rx_data = b;
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic radio_pop(input string req, input logic [7:0] exp);
        chk(req, tx_data, exp);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] st;
        chk("R12 miso low when idle", spi_miso, 1'b0);
        chk("R13 tx empty after reset", tx_empty, 1'b1);
        chk("R13 rx not full after reset", rx_full, 1'b0);
        read_status(st);
        chk("R1 reset status", st, 8'h00);
    endtask

    task automatic t_strobes();
        logic [7:0] s0, s1, s2;
        int base;
        base = stb_count;
        radio_push(8'h5A);
        cs_low();
        xfer(8'h03, s0);
        xfer(8'h45, s1);
        xfer(8'h0A, s2);
        cs_high();
        chk("R2 three chained strobes", stb_count - base, 3);
        chk("R2 last strobe code", stb_last, 4'hA);
        chk("R1 status on first address", s0, 8'h01);
        chk("R1 status on chained address", s2, 8'h01);
        strobe(8'h09);
        read_status(s0);
        chk("R3 rx flush clears rx_avail", s0, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d, hi, lo;
        int base;
        base = stb_count;
        cs_low();
        xfer(8'h12, d);
        xfer(8'hBE, d);
        xfer(8'hEF, d);
        xfer(8'h02, d);
        xfer(8'h52, d);
        xfer(8'h00, hi);
        xfer(8'h00, lo);
        cs_high();
        chk("R4 reg write stored", regs[18], 16'hBEEF);
        chk("R4 reg read high byte", hi, 8'hBE);
        chk("R4 reg read low byte", lo, 8'hEF);
        chk("R4 strobe after reg write decoded", stb_count - base, 1);
        chk("R4 chained strobe code", stb_last, 4'h2);
    endtask

    task automatic t_txburst();
        logic [7:0] a, e0, e1, e2;
        int base;
        base = stb_count;
        radio_push(8'h77);
        cs_low();
        xfer(8'h3E, a);
        xfer(8'hA1, e0);
        xfer(8'h08, e1);
        xfer(8'h3C, e2);
        cs_high();
        chk("R5 status echo byte0", e0, 8'h01);
        chk("R5 status echo byte1", e1, 8'h01);
        chk("R5 status echo byte2", e2, 8'h01);
        chk("R5 strobe-like data not a strobe", stb_count - base, 0);
        radio_pop("R5 tx byte0", 8'hA1);
        radio_pop("R5 tx byte1", 8'h08);
        radio_pop("R5 tx byte2", 8'h3C);
        chk("R5 tx drained", tx_empty, 1'b1);
        strobe(8'h09);
    endtask

    task automatic t_txread();
        logic [7:0] d, r0, r1;
        cs_low();
        xfer(8'h3E, d);
        xfer(8'h11, d);
        xfer(8'h22, d);
        cs_high();
        cs_low();
        xfer(8'h7E, d);
        xfer(8'h55, r0);
        xfer(8'h66, r1);
        cs_high();
        chk("R6 tx read returns zero 0", r0, 8'h00);
        chk("R6 tx read returns zero 1", r1, 8'h00);
        radio_pop("R6 tx unchanged 0", 8'h11);
        radio_pop("R6 tx unchanged 1", 8'h22);
        chk("R6 nothing appended by read", tx_empty, 1'b1);
    endtask

    task automatic t_rx();
        logic [7:0] a, r0, r1, r2, r3, r4;
        radio_push(8'h81);
        radio_push(8'h42);
        radio_push(8'hC3);
        cs_low();
        xfer(8'h7F, a);
        xfer(8'h00, r0);
        xfer(8'h00, r1);
        xfer(8'h00, r2);
        xfer(8'h00, r3);
        xfer(8'h00, r4);
        cs_high();
        chk("R1 status with rx data", a, 8'h01);
        chk("R7 R12 rx byte0 msb first", r0, 8'h81);
        chk("R7 rx byte1", r1, 8'h42);
        chk("R7 rx byte2", r2, 8'hC3);
        chk("R7 empty read zero", r3, 8'h00);
        chk("R7 empty read zero again", r4, 8'h00);
        radio_push(8'hC4);
        cs_low();
        xfer(8'h7F, a);
        xfer(8'h00, r0);
        cs_high();
        chk("R7 pointers unchanged by empty read", r0, 8'hC4);
        read_status(a);
        chk("R7 rx empty after read", a, 8'h00);
    endtask

    task automatic t_rxwrite();
        logic [7:0] d, r0, r1, r2;
        cs_low();
        xfer(8'h3F, d);
        xfer(8'hD1, d);
        xfer(8'hD2, d);
        cs_high();
        cs_low();
        xfer(8'h7F, d);
        xfer(8'h00, r0);
        xfer(8'h00, r1);
        xfer(8'h00, r2);
        cs_high();
        chk("R8 rx written byte0", r0, 8'hD1);
        chk("R8 rx written byte1", r1, 8'hD2);
        chk("R8 rx then empty", r2, 8'h00);
    endtask

    task automatic t_overflow();
        logic [7:0] d, e128, e129, st;
        int bad;
        cs_low();
        xfer(8'h3E, d);
        for (int i = 0; i < 130; i++) begin
            xfer(8'(i + 3), d);
            if (i == 128) e128 = d;
            if (i == 129) e129 = d;
        end
        cs_high();
        chk("R9 echo before drop", e128, 8'h00);
        chk("R9 echo after drop shows overflow", e129, 8'h04);
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            if (tx_data !== 8'(i + 3)) bad++;
            tx_pop = 1'b1;
            @(negedge clk);
            tx_pop = 1'b0;
            @(negedge clk);
        end
        chk("R13 128 bytes kept in order", bad, 0);
        chk("R9 R13 dropped bytes absent", tx_empty, 1'b1);
        read_status(st);
        chk("R9 tx overflow sticky", st, 8'h04);
        strobe(8'h08);
        read_status(st);
        chk("R3 tx flush clears overflow", st, 8'h00);
        for (int i = 0; i < 129; i++) radio_push(8'(i));
        chk("R13 rx full at 128", rx_full, 1'b1);
        read_status(st);
        chk("R9 rx overflow flag", st, 8'h09);
        strobe(8'h09);
        read_status(st);
        chk("R3 rx flush clears queue and flag", st, 8'h00);
    endtask

    task automatic t_underflow();
        logic [7:0] st;
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        @(negedge clk);
        read_status(st);
        chk("R10 underflow set", st, 8'h02);
        read_status(st);
        chk("R10 underflow sticky", st, 8'h02);
        strobe(8'h08);
        read_status(st);
        chk("R10 R3 underflow cleared by flush", st, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        int base;
        base = stb_count;
        cs_low();
        partial(8'h3E, 5);
        cs_high();
        cs_low();
        xfer(8'h04, d);
        cs_high();
        chk("R11 partial byte discarded, strobe decoded", stb_count - base, 1);
        chk("R11 strobe code after abort", stb_last, 4'h4);
        cs_low();
        xfer(8'h3E, d);
        xfer(8'h9A, d);
        partial(8'hFF, 3);
        cs_high();
        radio_pop("R11 full byte kept", 8'h9A);
        chk("R11 partial data byte not written", tx_empty, 1'b1);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        t_reset();
        t_strobes();
        t_regs();
        t_txburst();
        t_txread();
        t_rx();
        t_rxwrite();
        t_overflow();
        t_underflow();
        t_abort();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule